// File: doc/BRIEF.md
# Cascaded Up/Down Timer Pair with Cross-Channel Capture

The block holds two counter channels, a lower one and an upper one, each `CNT_W` bits wide (16 by default). Either channel can free-run, counting up once per clock. The lower channel can instead follow a two-phase quadrature input. The upper channel can be chained to the lower one, so that the pair forms a single `2*CNT_W`-bit up/down position count. In that chained setup the upper counter steps only when the lower counter wraps, and it steps in the direction of the wrap.

Each channel owns two capture registers, A and B, and each has a capture pin of the same name. A capture register records its own channel's counter when its pin rises. Software can also let a capture register fire on the matching pin of the other channel, so that one pin edge can freeze both halves of the chained count.

All configuration goes through a small write-only register port. Counter values and capture registers are visible on output ports.

Top module: `casc_timer_pair`

## Requirements
- R1: After reset, both counters, all four capture registers, the mode field, both start bits and all four cross-capture enables are 0.
- R2: Writes with `wr_en_i` high decode `wr_addr_i` as follows. Address 0 loads the lower counter and address 1 loads the upper counter. Address 2 is the mode register: bit 3 selects phase counting for the lower channel, and bits 2:0 select the upper channel's count source. Address 3 holds the start bits: bit 0 for the lower channel and bit 1 for the upper channel. Address 4 holds the cross-capture enables: bit 0 lets lower A take the upper A pin, bit 1 lets lower B take the upper B pin, bit 2 lets upper A take the lower A pin, and bit 3 lets upper B take the lower B pin.
- R3: A write to a counter takes effect at the next clock edge and overrides any count in that cycle.
- R4: A counter whose start bit is 0 holds its value. Only a direct write changes it.
- R5: In phase mode the lower counter decodes every edge of both phase inputs, written as {a,b}. The order 00→01→11→10→00 counts up by one per edge and the reverse order counts down. A change of both inputs at once is ignored. The phase inputs pass through two synchroniser flops.
- R6: When phase mode is off, a started lower counter adds one each cycle. When the upper source field is not 111, a started upper counter adds one each cycle.
- R7: With the upper source field at 111, the upper counter adds one when the lower counter wraps from all-ones to 0 and subtracts one when it wraps from 0 to all-ones. It does not change otherwise.
- R8: The chained count advances only while both start bits are 1. If the upper start bit is 0, a lower wrap leaves the upper counter unchanged.
- R9: Each capture pin passes through two synchroniser flops. A rising edge, and not a falling edge, loads the owning channel's current counter value into that pin's capture register.
- R10: A capture register with its cross enable at 0 fires only on its own pin. With the enable at 1 it also fires on a rising edge of the other channel's pin of the same letter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | CNT_W | Write data |
| phase_a_i | input | 1 | Quadrature phase A |
| phase_b_i | input | 1 | Quadrature phase B |
| cap_lo_a_i | input | 1 | Lower channel capture pin A |
| cap_lo_b_i | input | 1 | Lower channel capture pin B |
| cap_hi_a_i | input | 1 | Upper channel capture pin A |
| cap_hi_b_i | input | 1 | Upper channel capture pin B |
| cnt_lo_o | output | CNT_W | Lower counter |
| cnt_hi_o | output | CNT_W | Upper counter |
| cap_lo_a_o | output | CNT_W | Lower capture register A |
| cap_lo_b_o | output | CNT_W | Lower capture register B |
| cap_hi_a_o | output | CNT_W | Upper capture register A |
| cap_hi_b_o | output | CNT_W | Upper capture register B |

## Verification
The hardest case to reach is a wrap of the lower counter in each direction while the upper counter is chained. Reaching it through quadrature edges alone would take tens of thousands of steps. The stimulus therefore preloads the lower counter just below the wrap point and then runs a long random walk of forward steps, reverse steps and invalid double changes. That walk crosses the boundary many times in both directions, and a 32-bit model checks every step. A random phase also writes counter values, cross enables and pin masks, so that own-pin and paired-pin captures overlap.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_START  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_XCAP   = 3'd4;

  localparam logic [2:0] SRC_CASCADE = 3'b111;

  localparam int unsigned MODE_PHASE_BIT = 3;
  localparam int unsigned N_CAP          = 4;

  typedef struct packed {
    logic up;
    logic dn;
  } step_t;
endpackage

// File: rtl/ctp_sync.sv
module ctp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ctp_quad_dec.sv
module ctp_quad_dec
  import ctp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  a_i,
  input  logic  b_i,
  output step_t step_o
);
  logic [1:0] prev_q;
  logic       single;

  // exactly one input changed
  assign single = ^({a_i, b_i} ^ prev_q);

  always_comb begin
    step_o.up = single & (a_i == prev_q[0]);
    step_o.dn = single & (a_i != prev_q[0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 2'b00;
    else         prev_q <= {a_i, b_i};
  end
endmodule

// File: rtl/ctp_counter.sv
module ctp_counter
  import ctp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  step_t            step_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             go_up, go_dn;

  assign go_up = run_i & ~ld_i & step_i.up & ~step_i.dn;
  assign go_dn = run_i & ~ld_i & step_i.dn & ~step_i.up;
  assign ovf_o = go_up & (cnt_q == {CNT_W{1'b1}});
  assign unf_o = go_dn & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (go_up) cnt_q <= cnt_q + 1'b1;
    else if (go_dn) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ctp_capture.sv
module ctp_capture #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             peer_rise_i,
  input  logic             peer_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             rise_o,
  output logic             fire_o,
  output logic [CNT_W-1:0] cap_o
);
  logic             lvl_q;
  logic [CNT_W-1:0] cap_q;

  assign rise_o = lvl_i & ~lvl_q;
  // simultaneous own and peer edges collapse into one load
  assign fire_o = rise_o | (peer_en_i & peer_rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cap_q <= '0;
    end else begin
      lvl_q <= lvl_i;
      if (fire_o) cap_q <= cnt_i;
    end
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/casc_timer_pair.sv
module casc_timer_pair
  import ctp_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              phase_a_i,
  input  logic              phase_b_i,
  input  logic              cap_lo_a_i,
  input  logic              cap_lo_b_i,
  input  logic              cap_hi_a_i,
  input  logic              cap_hi_b_i,
  output logic [CNT_W-1:0]  cnt_lo_o,
  output logic [CNT_W-1:0]  cnt_hi_o,
  output logic [CNT_W-1:0]  cap_lo_a_o,
  output logic [CNT_W-1:0]  cap_lo_b_o,
  output logic [CNT_W-1:0]  cap_hi_a_o,
  output logic [CNT_W-1:0]  cap_hi_b_o
);
  localparam int unsigned MODE_W = MODE_PHASE_BIT + 1;

  logic [MODE_W-1:0] mode_q;
  logic [1:0]        start_q;
  logic [N_CAP-1:0]  xcap_q;

  logic wr_lo, wr_hi, casc, lo_phase;
  logic pa_s, pb_s;
  step_t quad_step, lo_step, hi_step;
  logic lo_ovf, lo_unf, hi_ovf, hi_unf;

  logic [CNT_W-1:0] cnt [2];
  logic [CNT_W-1:0] cap_val [N_CAP];
  logic [N_CAP-1:0] pin_raw, pin_s, pin_rise, cap_fire;

  assign wr_lo    = wr_en_i && (wr_addr_i == ADDR_CNT_LO);
  assign wr_hi    = wr_en_i && (wr_addr_i == ADDR_CNT_HI);
  assign casc     = (mode_q[2:0] == SRC_CASCADE);
  assign lo_phase = mode_q[MODE_PHASE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      start_q <= '0;
      xcap_q  <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_MODE:  mode_q  <= wr_data_i[MODE_W-1:0];
        ADDR_START: start_q <= wr_data_i[1:0];
        ADDR_XCAP:  xcap_q  <= wr_data_i[N_CAP-1:0];
        default: ;
      endcase
    end
  end

  ctp_sync #(.STAGES(SYNC_STAGES)) u_sync_pa (
    .clk_i, .rst_ni, .d_i(phase_a_i), .q_o(pa_s)
  );
  ctp_sync #(.STAGES(SYNC_STAGES)) u_sync_pb (
    .clk_i, .rst_ni, .d_i(phase_b_i), .q_o(pb_s)
  );

  ctp_quad_dec u_quad (
    .clk_i, .rst_ni, .a_i(pa_s), .b_i(pb_s), .step_o(quad_step)
  );

  always_comb begin
    lo_step = lo_phase ? quad_step : '{up: 1'b1, dn: 1'b0};
    hi_step = casc ? '{up: lo_ovf, dn: lo_unf} : '{up: 1'b1, dn: 1'b0};
  end

  ctp_counter #(.CNT_W(CNT_W)) u_cnt_lo (
    .clk_i, .rst_ni,
    .run_i(start_q[0]), .step_i(lo_step),
    .ld_i(wr_lo), .ld_val_i(wr_data_i),
    .cnt_o(cnt[0]), .ovf_o(lo_ovf), .unf_o(lo_unf)
  );

  ctp_counter #(.CNT_W(CNT_W)) u_cnt_hi (
    .clk_i, .rst_ni,
    .run_i(start_q[1]), .step_i(hi_step),
    .ld_i(wr_hi), .ld_val_i(wr_data_i),
    .cnt_o(cnt[1]), .ovf_o(hi_ovf), .unf_o(hi_unf)
  );

  // upper wrap events have no consumer in this block
  logic hi_wrap_unused;
  assign hi_wrap_unused = hi_ovf ^ hi_unf;

  // index: 0 lo A, 1 lo B, 2 hi A, 3 hi B; peer of i is i^2
  assign pin_raw = {cap_hi_b_i, cap_hi_a_i, cap_lo_b_i, cap_lo_a_i};

  for (genvar i = 0; i < N_CAP; i++) begin : g_cap
    localparam int unsigned PEER = i ^ 2;
    localparam int unsigned CH   = i / 2;

    ctp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i, .rst_ni, .d_i(pin_raw[i]), .q_o(pin_s[i])
    );

    ctp_capture #(.CNT_W(CNT_W)) u_cap (
      .clk_i, .rst_ni,
      .lvl_i(pin_s[i]),
      .peer_rise_i(pin_rise[PEER]),
      .peer_en_i(xcap_q[i]),
      .cnt_i(cnt[CH]),
      .rise_o(pin_rise[i]),
      .fire_o(cap_fire[i]),
      .cap_o(cap_val[i])
    );
  end

  assign cnt_lo_o   = cnt[0];
  assign cnt_hi_o   = cnt[1];
  assign cap_lo_a_o = cap_val[0];
  assign cap_lo_b_o = cap_val[1];
  assign cap_hi_a_o = cap_val[2];
  assign cap_hi_b_o = cap_val[3];
endmodule

// File: rtl/casc_timer_pair_chk.sv
module casc_timer_pair_chk
  import ctp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [CNT_W-1:0]  wr_data_i,
  input logic [CNT_W-1:0]  cnt_lo_o,
  input logic [CNT_W-1:0]  cnt_hi_o,
  input logic [CNT_W-1:0]  cap_lo_a_o,
  input logic [CNT_W-1:0]  cap_hi_b_o,
  input logic [3:0]        mode_q,
  input logic [1:0]        start_q,
  input logic [N_CAP-1:0]  cap_fire
);
  logic wr_lo, wr_hi, casc;
  assign wr_lo = wr_en_i && (wr_addr_i == ADDR_CNT_LO);
  assign wr_hi = wr_en_i && (wr_addr_i == ADDR_CNT_HI);
  assign casc  = (mode_q[2:0] == SRC_CASCADE);

  p_load_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> cnt_lo_o == $past(wr_data_i));

  p_load_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi |=> cnt_hi_o == $past(wr_data_i));

  p_hold_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_q[0] && !wr_lo) |=> $stable(cnt_lo_o));

  p_hold_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_q[1] && !wr_hi) |=> $stable(cnt_hi_o));

  p_casc_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (casc && !wr_hi && cnt_lo_o != {CNT_W{1'b1}} && cnt_lo_o != '0)
      |=> $stable(cnt_hi_o));

  p_casc_unit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (casc && !wr_hi) |=> (cnt_hi_o == $past(cnt_hi_o)
                          || cnt_hi_o == $past(cnt_hi_o) + 1'b1
                          || cnt_hi_o == $past(cnt_hi_o) - 1'b1));

  p_cap_lo_a_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_fire[0] |=> cap_lo_a_o == $past(cnt_lo_o));

  p_cap_hi_b_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_fire[3] |=> cap_hi_b_o == $past(cnt_hi_o));

  p_cap_lo_a_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap_lo_a_o) |-> $past(cap_fire[0]));
endmodule

bind casc_timer_pair casc_timer_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .cnt_lo_o(cnt_lo_o), .cnt_hi_o(cnt_hi_o),
  .cap_lo_a_o(cap_lo_a_o), .cap_hi_b_o(cap_hi_b_o),
  .mode_q(mode_q), .start_q(start_q), .cap_fire(cap_fire)
);

// File: tb/casc_timer_pair_test.sv
module casc_timer_pair_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic pa = 1'b0, pb = 1'b0;
  logic [3:0] pins = '0;  // 0 loA, 1 loB, 2 hiA, 3 hiB
  logic [W-1:0] cnt_lo, cnt_hi, c_la, c_lb, c_ha, c_hb;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  casc_timer_pair uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .phase_a_i(pa), .phase_b_i(pb),
    .cap_lo_a_i(pins[0]), .cap_lo_b_i(pins[1]),
    .cap_hi_a_i(pins[2]), .cap_hi_b_i(pins[3]),
    .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi),
    .cap_lo_a_o(c_la), .cap_lo_b_o(c_lb),
    .cap_hi_a_o(c_ha), .cap_hi_b_o(c_hb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // quadrature position in the forward cycle 00,01,11,10
  function automatic int qpos(input logic [1:0] s);
    case (s)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int qdelta(input logic [1:0] p, input logic [1:0] c);
    int d;
    d = (qpos(c) - qpos(p) + 4) % 4;
    if (d == 1) return 1;
    if (d == 3) return -1;
    return 0;
  endfunction

  task automatic phase_to(input logic [1:0] s);
    @(negedge clk);
    {pa, pb} = s;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    pins = m;
    repeat (4) @(negedge clk);
    pins = '0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp32;
    logic [1:0]  cur, nxt;
    logic [W-1:0] held;
    logic [W-1:0] e_cap [4];
    logic [W-1:0] vlo, vhi;
    logic [3:0] xe, m, f;
    void'($urandom(32'h5eed_1234));

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 cnt_lo", {16'h0, cnt_lo}, 0);
    chk("R1 cnt_hi", {16'h0, cnt_hi}, 0);
    chk("R1 caps", {c_la | c_lb, c_ha | c_hb}, 0);

    // free-running lower counter, write priority
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0001);
    wr(3'd0, 16'h1000);
    chk("R3 write over count", {16'h0, cnt_lo}, 32'h1000);
    repeat (10) @(negedge clk);
    chk("R6 lo free count", {16'h0, cnt_lo}, 32'h100a);
    chk("R4 hi held while stopped", {16'h0, cnt_hi}, 0);
    wr(3'd3, 16'h0000);
    held = cnt_lo;
    repeat (6) @(negedge clk);
    chk("R4 lo held after stop", {16'h0, cnt_lo}, {16'h0, held});

    // upper free count (source not 111)
    wr(3'd3, 16'h0002);
    held = cnt_hi;
    repeat (7) @(negedge clk);
    chk("R6 hi free count", {16'h0, cnt_hi}, {16'h0, held} + 7);
    wr(3'd3, 16'h0000);

    // cascade with phase mode
    wr(3'd2, 16'h000f);
    wr(3'd0, 16'hfffe);
    wr(3'd1, 16'h0005);
    wr(3'd3, 16'h0003);
    repeat (3) @(negedge clk);
    exp32 = 32'h0005_fffe;
    chk("R2 R7 preload", {cnt_hi, cnt_lo}, exp32);

    cur = {pa, pb};
    for (int k = 0; k < 400; k++) begin
      int r;
      r = int'($urandom % 8);
      if (r == 0)      nxt = ~cur;
      else if (r < 5)  case (cur) 2'b00: nxt = 2'b01; 2'b01: nxt = 2'b11; 2'b11: nxt = 2'b10; default: nxt = 2'b00; endcase
      else             case (cur) 2'b00: nxt = 2'b10; 2'b10: nxt = 2'b11; 2'b11: nxt = 2'b01; default: nxt = 2'b00; endcase
      phase_to(nxt);
      exp32 = exp32 + 32'(qdelta(cur, nxt));
      cur = nxt;
      chk(r == 0 ? "R5 invalid ignored" : "R5 R7 phase walk", {cnt_hi, cnt_lo}, exp32);
    end

    // directed wrap both ways
    wr(3'd0, 16'hffff);
    wr(3'd1, 16'h0100);
    case (cur) 2'b00: nxt = 2'b01; 2'b01: nxt = 2'b11; 2'b11: nxt = 2'b10; default: nxt = 2'b00; endcase
    phase_to(nxt);
    chk("R7 overflow", {cnt_hi, cnt_lo}, 32'h0101_0000);
    phase_to(cur);
    chk("R7 underflow", {cnt_hi, cnt_lo}, 32'h0100_ffff);

    // upper start cleared: no carry
    wr(3'd3, 16'h0001);
    phase_to(nxt);
    chk("R8 hi stopped across wrap", {cnt_hi, cnt_lo}, 32'h0100_0000);
    cur = nxt;

    // captures
    wr(3'd3, 16'h0000);
    wr(3'd0, 16'h1234);
    wr(3'd1, 16'habcd);
    pulse(4'b0100);
    chk("R9 hi A own pin", {16'h0, c_ha}, 32'habcd);
    chk("R10 lo A cross off", {16'h0, c_la}, 0);
    pulse(4'b0010);
    chk("R9 lo B own pin", {16'h0, c_lb}, 32'h1234);
    chk("R10 hi B cross off", {16'h0, c_hb}, 0);
    wr(3'd4, 16'h0001);
    wr(3'd0, 16'h2222);
    pulse(4'b0100);
    chk("R10 lo A from hi pin", {16'h0, c_la}, 32'h2222);
    chk("R9 hi A again", {16'h0, c_ha}, 32'habcd);
    wr(3'd4, 16'h0008);
    wr(3'd0, 16'h3333);
    wr(3'd1, 16'h4444);
    pulse(4'b0010);
    chk("R10 hi B from lo pin", {16'h0, c_hb}, 32'h4444);
    chk("R9 lo B", {16'h0, c_lb}, 32'h3333);

    e_cap[0] = c_la; e_cap[1] = c_lb; e_cap[2] = c_ha; e_cap[3] = c_hb;
    for (int k = 0; k < 60; k++) begin
      vlo = W'($urandom); vhi = W'($urandom);
      xe = 4'($urandom); m = 4'($urandom);
      wr(3'd0, vlo);
      wr(3'd1, vhi);
      wr(3'd4, {12'h0, xe});
      pulse(m);
      for (int i = 0; i < 4; i++) begin
        f[i] = m[i] | (xe[i] & m[i ^ 2]);
        if (f[i]) e_cap[i] = (i < 2) ? vlo : vhi;
      end
      chk("R9 R10 rand lo A", {16'h0, c_la}, {16'h0, e_cap[0]});
      chk("R9 R10 rand lo B", {16'h0, c_lb}, {16'h0, e_cap[1]});
      chk("R9 R10 rand hi A", {16'h0, c_ha}, {16'h0, e_cap[2]});
      chk("R9 R10 rand hi B", {16'h0, c_hb}, {16'h0, e_cap[3]});
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule